// File: doc/BRIEF.md
# Multi-Page-Size Associative Translation Buffer

This block holds a set of address translations and answers lookups against all of them at once. Each slot pairs a 64-bit tag with a 64-bit translation word. The tag holds a virtual page and a 13-bit context. The translation word holds a valid flag, a page-size code, a physical page, rights bits and a lock flag. The page-size code lets every slot cover 8 KB, 64 KB, 512 KB or 4 MB, so each slot applies its own compare mask to the incoming virtual address.

A lookup enters on a valid/ready request stream and carries the virtual address and three flags: user mode, write, and fetch side. The current context is a plain input. Each request produces exactly one response on a valid/ready response stream. The response is a hit with a physical address and rights, a protection fault, or a miss. Requests are accepted only when the response register is empty or is being drained in the same cycle. A stalled response holds every field unchanged until it is taken.

Data-side and fetch-side translation each have their own enable. When an enable is off, that side passes the address through. A protection fault updates a small status register and latches the faulting address; a second fault before the status register is cleared marks overflow. Slots are written through a fill port, either at a named index or at a slot chosen by a round-robin pointer that skips locked slots. Refill from page tables is left to software.

Top module: `mpsz_tlb`

## Requirements
- R1: During and after reset, `rsp_valid` is 0, `fsr` is 0 and `far` is 0. Every slot is cleared: tag 0, translation word 0.
- R2: When the enable for the request's side is 0, the response is a hit with `rsp_pa` equal to `req_va[PA_W-1:0]`. The data side (`req_fetch`=0) gets `rsp_rd`=1 and `rsp_wr`=1. The fetch side gets only `rsp_ex`=1. The two enables act independently.
- R3: A slot matches when tag bits [12:0] equal `cur_ctx`, and the virtual address ANDed with the slot's page mask equals the tag with bits [12:0] cleared. The page mask comes from translation-word bits [62:61]: 0 clears address bits [12:0], 1 clears [15:0], 2 clears [18:0], 3 clears [21:0].
- R4: On a hit, `rsp_pa` takes the translation word's bits at and above the page mask and the virtual-address bits below it, over bits [PA_W-1:0].
- R5: With translation on and no slot matching, the response kind is miss (`rsp_kind`=2), `rsp_pa` is 0, all rights are 0, and `fsr`/`far` are left unchanged. Kind codes: 0 hit, 1 fault, 2 miss.
- R6: A matching slot whose bit 63 (valid) is 0 gives a fault (kind 1, `rsp_pa` 0, no rights). This includes the cleared slots after reset, which match context 0 at addresses below 8 KB.
- R7: A matching valid slot faults if bit 2 (privileged) is set and `req_user` is 1. On the data side it also faults if bit 1 (writable) is 0 and `req_write` is 1. The fetch side never checks the write flag.
- R8: A data-side hit returns `rsp_rd`=1 and `rsp_wr` equal to bit 1. A fetch-side hit returns only `rsp_ex`=1.
- R9: A fault first sets `fsr` to 2 if it was nonzero, then ORs in {user, write, 0, 1} (bit 3 user, bit 2 write, bit 0 set). It also loads `far` with the full virtual address. `fsr_clr` clears `fsr`; a fault in the same cycle is recorded on the cleared value.
- R10: When several slots match, the lowest-index slot decides the response.
- R11: With `fill_at_idx`=1, `fill_en` writes the slot `fill_idx`. With `fill_at_idx`=0, it writes the first slot at or after the replacement pointer whose bit 6 (locked) is 0, and the pointer moves to the slot after that one. Explicit fills leave the pointer alone. The pointer starts at 0. Lookups see a fill from the next cycle.
- R12: `req_ready` is high when `rsp_valid` is 0 or `rsp_ready` is 1. A response that is not taken holds all its fields. Responses come out in request order, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_xlat_en | input | 1 | Data-side translation enable |
| fetch_xlat_en | input | 1 | Fetch-side translation enable |
| cur_ctx | input | CTX_W | Current context number |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_va | input | 64 | Virtual address |
| req_user | input | 1 | Access from user mode |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | 0 hit, 1 fault, 2 miss |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right |
| rsp_ex | output | 1 | Execute right |
| fill_en | input | 1 | Write one slot |
| fill_at_idx | input | 1 | 1: use fill_idx, 0: use replacement pointer |
| fill_idx | input | IDX_W | Explicit slot index |
| fill_tag | input | 64 | Tag to write |
| fill_tte | input | 64 | Translation word to write |
| fsr_clr | input | 1 | Clear fault status |
| fsr | output | 4 | Fault status |
| far | output | 64 | Faulting virtual address |

## Verification
The assertions assume that `req_valid` is low while reset is held, and that the response consumer only changes `rsp_ready` between clock edges. The stability check under stall relies on the producer side, and holds for any `rsp_ready` pattern. The fault-logging check assumes no clear arrives in the cycle after a fault. The stimulus meets all of this: inputs change only on falling edges, back-pressure changes just after rising edges, and `fsr_clr` is only pulsed after the fault it follows has been checked.

// File: rtl/mpsz_tlb_pkg.sv
package mpsz_tlb_pkg;

  typedef enum logic [1:0] {
    XT_HIT   = 2'd0,
    XT_FAULT = 2'd1,
    XT_MISS  = 2'd2
  } xt_kind_e;

  localparam int XT_BIT_VALID = 63;
  localparam int XT_BIT_LOCK  = 6;
  localparam int XT_BIT_PRIV  = 2;
  localparam int XT_BIT_WR    = 1;

  // page-size code -> mask keeping the page-number bits
  function automatic logic [63:0] xt_size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return ~64'h0000_0000_0000_1FFF;
      2'd1:    return ~64'h0000_0000_0000_FFFF;
      2'd2:    return ~64'h0000_0000_0007_FFFF;
      default: return ~64'h0000_0000_003F_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/mpsz_tlb_match.sv
module mpsz_tlb_match
  import mpsz_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [63:0]      tag_q [ENTRIES],
  input  logic [1:0]       sz_q  [ENTRIES],
  input  logic [63:0]      va,
  input  logic [CTX_W-1:0] ctx,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  localparam logic [63:0] TAG_PAGE = {{(64-CTX_W){1'b1}}, {CTX_W{1'b0}}};

  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [63:0] msk;
    assign msk      = xt_size_mask(sz_q[i]);
    assign match[i] = (tag_q[i][CTX_W-1:0] == ctx) &&
                      ((va & msk) == (tag_q[i] & TAG_PAGE));
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mpsz_tlb_victim.sv
module mpsz_tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] locked,
  input  logic               fill_auto,
  output logic [IDX_W-1:0]   pick
);
  logic [IDX_W-1:0] ptr_q;
  logic             found;

  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      int cand;
      cand = (int'(ptr_q) + k) % ENTRIES;
      if (!found && !locked[cand]) begin
        pick  = IDX_W'(cand);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_q <= '0;
    else if (fill_auto) ptr_q <= IDX_W'((int'(pick) + 1) % ENTRIES);
  end

endmodule

// File: rtl/mpsz_tlb_fault.sv
module mpsz_tlb_fault (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flt,
  input  logic        flt_user,
  input  logic        flt_write,
  input  logic [63:0] flt_va,
  input  logic        clr,
  output logic [3:0]  fsr,
  output logic [63:0] far
);
  logic [3:0] base;

  always_comb begin
    base = clr ? 4'd0 : fsr;
    if (base != 4'd0) base = 4'd2;  // overflow marker
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr <= '0;
      far <= '0;
    end else if (flt) begin
      fsr <= base | {flt_user, flt_write, 1'b0, 1'b1};
      far <= flt_va;
    end else if (clr) begin
      fsr <= '0;
    end
  end

endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb
  import mpsz_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13,
  parameter int PA_W    = 41,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_xlat_en,
  input  logic             fetch_xlat_en,
  input  logic [CTX_W-1:0] cur_ctx,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_va,
  input  logic             req_user,
  input  logic             req_write,
  input  logic             req_fetch,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_kind,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  input  logic             fill_en,
  input  logic             fill_at_idx,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [63:0]      fill_tag,
  input  logic [63:0]      fill_tte,
  input  logic             fsr_clr,
  output logic [3:0]       fsr,
  output logic [63:0]      far
);
  logic [63:0]        tag_q [ENTRIES];
  logic [63:0]        tte_q [ENTRIES];
  logic [1:0]         sz_q  [ENTRIES];
  logic [ENTRIES-1:0] locked;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_fields
    assign sz_q[i]   = tte_q[i][62:61];
    assign locked[i] = tte_q[i][XT_BIT_LOCK];
  end

  // ---------------- lookup ----------------
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [63:0]      hit_tte;
  logic [63:0]      hit_msk;

  mpsz_tlb_match #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_match (
    .tag_q  (tag_q),
    .sz_q   (sz_q),
    .va     (req_va),
    .ctx    (cur_ctx),
    .hit    (hit),
    .hit_idx(hit_idx)
  );

  assign hit_tte = tte_q[hit_idx];
  assign hit_msk = xt_size_mask(hit_tte[62:61]);

  logic unused_tte_mid;
  assign unused_tte_mid = ^hit_tte[60:PA_W];

  xt_kind_e        nx_kind;
  logic [PA_W-1:0] nx_pa;
  logic            nx_rd, nx_wr, nx_ex, xen, denied;

  always_comb begin
    xen    = req_fetch ? fetch_xlat_en : data_xlat_en;
    denied = !hit_tte[XT_BIT_VALID] ||
             (hit_tte[XT_BIT_PRIV] && req_user) ||
             (!req_fetch && !hit_tte[XT_BIT_WR] && req_write);
    nx_kind = XT_HIT;
    nx_pa   = '0;
    nx_rd   = 1'b0;
    nx_wr   = 1'b0;
    nx_ex   = 1'b0;
    if (!xen) begin
      nx_pa = req_va[PA_W-1:0];
      nx_rd = !req_fetch;
      nx_wr = !req_fetch;
      nx_ex = req_fetch;
    end else if (!hit) begin
      nx_kind = XT_MISS;
    end else if (denied) begin
      nx_kind = XT_FAULT;
    end else begin
      nx_pa = hit_tte[PA_W-1:0] & hit_msk[PA_W-1:0] |
              req_va[PA_W-1:0] & ~hit_msk[PA_W-1:0];
      nx_rd = !req_fetch;
      nx_wr = !req_fetch && hit_tte[XT_BIT_WR];
      nx_ex = req_fetch;
    end
  end

  // ---------------- response register ----------------
  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= XT_HIT;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= nx_kind;
      rsp_pa    <= nx_pa;
      rsp_rd    <= nx_rd;
      rsp_wr    <= nx_wr;
      rsp_ex    <= nx_ex;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // ---------------- fault status ----------------
  mpsz_tlb_fault u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt      (accept && (nx_kind == XT_FAULT)),
    .flt_user (req_user),
    .flt_write(req_write),
    .flt_va   (req_va),
    .clr      (fsr_clr),
    .fsr      (fsr),
    .far      (far)
  );

  // ---------------- fill ----------------
  logic [IDX_W-1:0] vic_pick, fill_tgt;

  mpsz_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .fill_auto(fill_en && !fill_at_idx),
    .pick     (vic_pick)
  );

  assign fill_tgt = fill_at_idx ? fill_idx : vic_pick;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end else if (fill_en && (fill_tgt == IDX_W'(i))) begin
        tag_q[i] <= fill_tag;
        tte_q[i] <= fill_tte;
      end
    end
  end

endmodule

// File: rtl/mpsz_tlb_chk.sv
module mpsz_tlb_chk #(
  parameter int PA_W = 41
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [1:0]      rsp_kind,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_rd,
  input logic            rsp_wr,
  input logic            rsp_ex,
  input logic            fsr_clr,
  input logic [3:0]      fsr
);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_pa) &&
                                $stable(rsp_rd) && $stable(rsp_wr) && $stable(rsp_ex)); // R12

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R12

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind != 2'd3); // R5

  AST_NO_RIGHTS_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind != 2'd0 |-> !rsp_rd && !rsp_wr && !rsp_ex && rsp_pa == '0); // R6

  AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ex |-> !rsp_rd && !rsp_wr); // R8

  AST_FAULT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready) && rsp_valid && rsp_kind == 2'd1 |-> fsr[0]); // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_clr && !(req_valid && req_ready) |=> fsr == 4'd0); // R9

endmodule

bind mpsz_tlb mpsz_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_kind (rsp_kind),
  .rsp_pa   (rsp_pa),
  .rsp_rd   (rsp_rd),
  .rsp_wr   (rsp_wr),
  .rsp_ex   (rsp_ex),
  .fsr_clr  (fsr_clr),
  .fsr      (fsr)
);

// File: tb/tb_mpsz_tlb.sv
module tb_mpsz_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 64;
  localparam int CTX_W      = 13;
  localparam int PA_W       = 41;
  localparam int IDX_W      = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             data_xlat_en, fetch_xlat_en;
  logic [CTX_W-1:0] cur_ctx;
  logic             req_valid, req_ready;
  logic [63:0]      req_va;
  logic             req_user, req_write, req_fetch;
  logic             rsp_valid, rsp_ready;
  logic [1:0]       rsp_kind;
  logic [PA_W-1:0]  rsp_pa;
  logic             rsp_rd, rsp_wr, rsp_ex;
  logic             fill_en, fill_at_idx;
  logic [IDX_W-1:0] fill_idx;
  logic [63:0]      fill_tag, fill_tte;
  logic             fsr_clr;
  logic [3:0]       fsr;
  logic [63:0]      far;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpsz_tlb #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .PA_W(PA_W)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0]      kind;
    logic [PA_W-1:0] pa;
    logic            rd, wr, ex;
    int              req;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input int r, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // back-pressure generator, changes just after the rising edge
  bit bp_on = 1'b0;
  int bp_cnt = 0;
  always @(posedge clk) begin
    #2;
    bp_cnt++;
    rsp_ready = bp_on ? (bp_cnt % 3 != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, 12, "unexpected response", {62'd0, rsp_kind}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_kind == e.kind, e.req, "kind", {62'd0, rsp_kind}, {62'd0, e.kind});
        chk(rsp_pa == e.pa && {rsp_rd, rsp_wr, rsp_ex} == {e.rd, e.wr, e.ex}, e.req,
            "pa/rights", {20'd0, rsp_rd, rsp_wr, rsp_ex, rsp_pa},
            {20'd0, e.rd, e.wr, e.ex, e.pa});
      end
    end
  end

  task automatic send(input logic [63:0] va, input bit user, input bit wr, input bit fetch,
                      input logic [1:0] kind, input logic [PA_W-1:0] pa,
                      input bit erd, input bit ewr, input bit eex, input int r);
    exp_t e;
    bit   rdy;
    @(negedge clk);
    req_va = va; req_user = user; req_write = wr; req_fetch = fetch; req_valid = 1'b1;
    e.kind = kind; e.pa = pa; e.rd = erd; e.wr = ewr; e.ex = eex; e.req = r;
    sb.push_back(e);
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic fill(input bit at_idx, input logic [IDX_W-1:0] idx,
                      input logic [63:0] tag, input logic [63:0] tte);
    @(negedge clk);
    fill_en = 1'b1; fill_at_idx = at_idx; fill_idx = idx; fill_tag = tag; fill_tte = tte;
    @(posedge clk);
    #1 fill_en = 1'b0;
  endtask

  task automatic clear_fsr();
    @(negedge clk);
    fsr_clr = 1'b1;
    @(posedge clk);
    #1 fsr_clr = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, 12, "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  localparam logic [1:0] K_HIT = 2'd0, K_FLT = 2'd1, K_MISS = 2'd2;

  initial begin
    rst_n = 1'b0; data_xlat_en = 1'b0; fetch_xlat_en = 1'b0; cur_ctx = 13'd5;
    req_valid = 1'b0; req_va = '0; req_user = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    rsp_ready = 1'b1; fill_en = 1'b0; fill_at_idx = 1'b0; fill_idx = '0;
    fill_tag = '0; fill_tte = '0; fsr_clr = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, 1, "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    chk(fsr == 4'd0, 1, "fsr after reset", {60'd0, fsr}, 64'd0);
    chk(far == 64'd0, 1, "far after reset", far, 64'd0);
    rst_n = 1'b1;

    // R2 both sides off: pass-through
    send(64'h0000_00AB_CDEF_0123, 0, 1, 0, K_HIT, 41'h0AB_CDEF_0123, 1, 1, 0, 2);
    send(64'h0000_0001_0000_4000, 1, 0, 1, K_HIT, 41'h001_0000_4000, 0, 0, 1, 2);
    // R2 data on, fetch off: independent enables
    data_xlat_en = 1'b1;
    send(64'h0000_0001_0000_4000, 0, 0, 1, K_HIT, 41'h001_0000_4000, 0, 0, 1, 2);
    send(64'h0000_0040_0000_1ABC, 0, 0, 0, K_MISS, '0, 0, 0, 0, 5); // R5 miss
    fetch_xlat_en = 1'b1;
    drain();

    // R6 reset-cleared slots match context 0 below 8 KB and fault
    cur_ctx = 13'd0;
    send(64'h0000_0000_0000_0100, 0, 0, 0, K_FLT, '0, 0, 0, 0, 6);
    @(negedge clk);
    chk(fsr == 4'd1, 9, "fsr after first fault", {60'd0, fsr}, 64'd1);
    chk(far == 64'h100, 9, "far after first fault", far, 64'h100);
    drain();
    clear_fsr();
    @(negedge clk);
    chk(fsr == 4'd0, 9, "fsr after clear", {60'd0, fsr}, 64'd0);
    cur_ctx = 13'd5;

    // R3 R4 R8 8 KB page, writable
    fill(1, 6'd3, 64'h0000_0040_0000_0005, 64'h8000_0001_2345_6002);
    send(64'h0000_0040_0000_1ABC, 1, 1, 0, K_HIT, 41'h001_2345_7ABC, 1, 1, 0, 4);
    cur_ctx = 13'd6;
    send(64'h0000_0040_0000_1ABC, 0, 0, 0, K_MISS, '0, 0, 0, 0, 3); // R3 context differs
    drain();
    cur_ctx = 13'd5;

    // R3 R8 4 MB page, privileged, read-only
    fill(1, 6'd10, 64'h0000_0080_0000_0005, 64'hE000_0000_4000_0004);
    send(64'h0000_0080_0023_4567, 0, 0, 0, K_HIT, 41'h000_4023_4567, 1, 0, 0, 3);
    send(64'h0000_0080_0023_4567, 1, 0, 0, K_FLT, '0, 0, 0, 0, 7); // R7 user on privileged
    @(negedge clk);
    chk(fsr == 4'd9, 9, "fsr user fault", {60'd0, fsr}, 64'd9);
    chk(far == 64'h0000_0080_0023_4567, 9, "far user fault", far, 64'h0000_0080_0023_4567);
    send(64'h0000_0080_0000_0010, 0, 1, 0, K_FLT, '0, 0, 0, 0, 7); // R7 write to read-only
    @(negedge clk);
    chk(fsr == 4'd7, 9, "fsr overflow", {60'd0, fsr}, 64'd7);
    drain();
    clear_fsr();
    // R7 fetch side ignores write flag, still checks privilege
    send(64'h0000_0080_0023_4567, 0, 1, 1, K_HIT, 41'h000_4023_4567, 0, 0, 1, 7);
    send(64'h0000_0080_0023_4567, 1, 0, 1, K_FLT, '0, 0, 0, 0, 7);
    drain();
    clear_fsr();

    // R3 R4 64 KB and 512 KB pages under back-pressure (R12)
    fill(1, 6'd20, 64'h0000_0001_0000_0005, 64'hA000_0002_0000_0002);
    fill(1, 6'd21, 64'h0000_0002_0000_0005, 64'hC000_0000_0300_0000);
    bp_on = 1'b1;
    send(64'h0000_0001_0000_ABCD, 0, 1, 0, K_HIT, 41'h002_0000_ABCD, 1, 1, 0, 4);
    send(64'h0000_0001_0000_E000, 0, 0, 0, K_HIT, 41'h002_0000_E000, 1, 1, 0, 3);
    send(64'h0000_0001_0001_0000, 0, 0, 0, K_MISS, '0, 0, 0, 0, 3);
    send(64'h0000_0002_0007_FFFF, 0, 0, 0, K_HIT, 41'h000_0307_FFFF, 1, 0, 0, 4);
    send(64'h0000_0002_0008_0000, 0, 0, 0, K_MISS, '0, 0, 0, 0, 12);
    drain();
    bp_on = 1'b0;

    // R10 two matching slots: lower index decides
    fill(1, 6'd30, 64'h0000_0005_0000_0005, 64'h8000_0000_0AAA_A002);
    fill(1, 6'd25, 64'h0000_0005_0000_0005, 64'h8000_0000_0BBB_C002);
    send(64'h0000_0005_0000_0010, 0, 0, 0, K_HIT, 41'h000_0BBB_C010, 1, 1, 0, 10);

    // R6 explicitly written invalid slot
    fill(1, 6'd40, 64'h0000_0007_0000_0005, 64'h0000_0000_0111_0002);
    send(64'h0000_0007_0000_0000, 0, 0, 0, K_FLT, '0, 0, 0, 0, 6);
    drain();
    clear_fsr();

    // R11 locked slot 0 is skipped by automatic fills; pointer advances
    fill(1, 6'd0, 64'h0000_0009_0000_0005, 64'h8000_0000_0222_0042);
    fill(0, 6'd0, 64'h0000_0040_0000_0005, 64'h8000_0000_0333_0000);
    send(64'h0000_0009_0000_0000, 0, 0, 0, K_HIT, 41'h000_0222_0000, 1, 1, 0, 11);
    send(64'h0000_0040_0000_0004, 0, 0, 0, K_HIT, 41'h000_0333_0004, 1, 0, 0, 11);
    fill(0, 6'd0, 64'h0000_0040_0000_0005, 64'h8000_0000_0444_0002);
    send(64'h0000_0040_0000_0004, 0, 0, 0, K_HIT, 41'h000_0333_0004, 1, 0, 0, 11);
    drain();

    // R5 misses leave fault status alone
    send(64'h0000_0777_0000_0000, 0, 0, 0, K_MISS, '0, 0, 0, 0, 5);
    drain();
    chk(fsr == 4'd0, 5, "fsr after miss", {60'd0, fsr}, 64'd0);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, 12, "responses outstanding", 64'(sb.size()), 64'd0);
    summary();
  end

endmodule